// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block watches thirty-two general-purpose input pins and turns their activity into one combined interrupt request for the processor. Each pin can trigger on a level or on an edge. A level pin fires on a high or a low level, as selected. An edge pin can be qualified to respond to rising edges, falling edges or both. It can then either latch the event until software clears it, or report it for a single cycle. A pin contributes to the interrupt output only when its pending bit and its enable bit are both set.

Software reaches the unit through a 16-bit register bus with a combinational read port and a single-cycle write strobe. Every per-pin control is split into a pair of halfword registers: the lower address holds pins 0–15 and the next halfword holds pins 16–31. Every pin passes through a two-stage synchroniser before any detection takes place.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every control register reads 0 and irqOut is low. With all pins low, the level/low-active default then makes every status bit read 1.
- R2: Byte addresses map as follows: status 0x08/0x0A, enable 0x0C/0x0E, trigger type 0x10/0x12, active level 0x14/0x16, hold select 0x18/0x1A, falling qualifier 0x20/0x22, rising qualifier 0x24/0x26. The lower address of each pair holds pins 0–15 in bits 0–15, and the upper address holds pins 16–31. Control registers read back what was written. Any other address, including odd addresses, reads 0 and ignores writes.
- R3: A pin change sampled at clock edge k is visible in status after edge k+2 and not before.
- R4: A pin whose type bit is 0 is level-triggered. Its status bit follows the synchronised pin: 1 when the pin equals its active-level bit (1 = high active, 0 = low active). A write-one to its status bit has no lasting effect.
- R5: A pin whose type bit is 1 is edge-triggered. A 0→1 transition is an event only if its rising bit is 1, and a 1→0 transition is an event only if its falling bit is 1. With both bits set, either transition is an event. With neither set, nothing is detected.
- R6: An edge pin with hold bit 1 keeps its status bit set until a 1 is written to that bit. Writing 0 leaves every status bit unchanged.
- R7: If an edge event on a hold pin lands in the same cycle as a write-one clear of that pin, the status bit stays set.
- R8: An edge pin with hold bit 0 shows each event in its status bit for exactly one cycle.
- R9: irqOut is high exactly when some pin has both its status bit and its enable bit set.
- R10: The hold bit has no effect on level-triggered pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 6 | Byte address of the register |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data for busAddr |
| pinIn | input | 32 | Asynchronous pin inputs |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench sweeps each of the 32 enable bits against a known pending pattern. A wrong AND/OR reduction or a swapped half would then raise the interrupt for the wrong pin. Edge detection is checked with four qualifier combinations interleaved across the pins. A design that ignored a qualifier, or swapped rising and falling, would latch the wrong bit pattern. The same-cycle clear and event case is timed to the exact edge, so a design that lets the clear win would lose the event. The two-edge synchroniser latency is checked on both sides. A missing stage or an extra stage would show the status one cycle too early or too late.

// File: rtl/gid_pkg.sv
package gid_pkg;

  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_EN,
    SEL_TYPE,
    SEL_LVL,
    SEL_HOLD,
    SEL_FALL,
    SEL_RISE
  } regSel_e;

  typedef struct packed {
    logic              wrStb;
    logic              hiHalf;
    regSel_e           sel;
    logic [HALF_W-1:0] wrData;
  } busCmd_t;

endpackage

// File: rtl/gid_ctrl.sv
module gid_ctrl
  import gid_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [HALF_W-1:0] busWrData,
  output busCmd_t           cmd
);

  regSel_e selDec;

  always_comb begin
    selDec = SEL_NONE;
    if (busAddr[0] == 1'b0) begin
      case (busAddr[ADDR_W-1:2])
        4'd2:    selDec = SEL_STAT;
        4'd3:    selDec = SEL_EN;
        4'd4:    selDec = SEL_TYPE;
        4'd5:    selDec = SEL_LVL;
        4'd6:    selDec = SEL_HOLD;
        4'd8:    selDec = SEL_FALL;
        4'd9:    selDec = SEL_RISE;
        default: selDec = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    cmd.sel    = selDec;
    cmd.hiHalf = busAddr[1];
    cmd.wrData = busWrData;
    cmd.wrStb  = busWrEn && (selDec != SEL_NONE);
  end

endmodule

// File: rtl/gid_pin_cell.sv
module gid_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pinRaw,
  input  logic typeBit,
  input  logic actHigh,
  input  logic holdBit,
  input  logic riseQ,
  input  logic fallQ,
  input  logic clrReq,
  output logic pending
);

  logic syncA, syncB, prevB;
  logic riseEv, fallEv, edgeEv, lvlHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= pinRaw;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_comb begin
    riseEv = syncB & ~prevB & riseQ;
    fallEv = ~syncB & prevB & fallQ;
    edgeEv = riseEv | fallEv;
    lvlHit = (syncB == actHigh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (!typeBit) begin
      pending <= lvlHit;
    end else if (holdBit) begin
      pending <= edgeEv | (pending & ~clrReq);
    end else begin
      pending <= edgeEv;
    end
  end

  // R6: a held event survives until cleared
  p_hold_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (typeBit && holdBit && pending && !clrReq) |=> pending);

  // R7: a fresh event beats a simultaneous clear
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (typeBit && holdBit && edgeEv && clrReq) |=> pending);

  // R8: pass-through edge status lasts one cycle only
  p_through_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (typeBit && !holdBit && !edgeEv) |=> !pending);

  // R5: no qualifier means no detection
  p_no_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (typeBit && !riseQ && !fallQ && !pending) |=> !pending);

  // R4, R10: level pins track the synchronised level whatever hold says
  p_level_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!typeBit && (syncB == actHigh)) |=> pending);

endmodule

// File: rtl/gid_datapath.sv
module gid_datapath
  import gid_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  busCmd_t             cmd,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [HALF_W-1:0]   rdData,
  output logic                irqOut
);

  localparam int NUM_HALVES = NUM_PINS / HALF_W;

  logic [NUM_PINS-1:0] enReg, typeReg, lvlReg, holdReg, fallReg, riseReg;
  logic [NUM_PINS-1:0] laneMask, wideData, clrVec, pendVec, rdVec;

  genvar h;
  generate
    for (h = 0; h < NUM_HALVES; h++) begin : g_lane
      assign laneMask[h*HALF_W +: HALF_W] = {HALF_W{cmd.hiHalf == h[0]}};
      assign wideData[h*HALF_W +: HALF_W] = cmd.wrData;
    end
  endgenerate

  function automatic logic [NUM_PINS-1:0] mergeHalf(
    input logic [NUM_PINS-1:0] oldVal,
    input logic [NUM_PINS-1:0] newVal,
    input logic [NUM_PINS-1:0] mask
  );
    return (oldVal & ~mask) | (newVal & mask);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg   <= '0;
      typeReg <= '0;
      lvlReg  <= '0;
      holdReg <= '0;
      fallReg <= '0;
      riseReg <= '0;
    end else if (cmd.wrStb) begin
      case (cmd.sel)
        SEL_EN:   enReg   <= mergeHalf(enReg,   wideData, laneMask);
        SEL_TYPE: typeReg <= mergeHalf(typeReg, wideData, laneMask);
        SEL_LVL:  lvlReg  <= mergeHalf(lvlReg,  wideData, laneMask);
        SEL_HOLD: holdReg <= mergeHalf(holdReg, wideData, laneMask);
        SEL_FALL: fallReg <= mergeHalf(fallReg, wideData, laneMask);
        SEL_RISE: riseReg <= mergeHalf(riseReg, wideData, laneMask);
        default: ;
      endcase
    end
  end

  assign clrVec = (cmd.wrStb && cmd.sel == SEL_STAT) ? (wideData & laneMask) : '0;

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      gid_pin_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .pinRaw  (pinIn[p]),
        .typeBit (typeReg[p]),
        .actHigh (lvlReg[p]),
        .holdBit (holdReg[p]),
        .riseQ   (riseReg[p]),
        .fallQ   (fallReg[p]),
        .clrReq  (clrVec[p]),
        .pending (pendVec[p])
      );
    end
  endgenerate

  always_comb begin
    case (cmd.sel)
      SEL_STAT: rdVec = pendVec;
      SEL_EN:   rdVec = enReg;
      SEL_TYPE: rdVec = typeReg;
      SEL_LVL:  rdVec = lvlReg;
      SEL_HOLD: rdVec = holdReg;
      SEL_FALL: rdVec = fallReg;
      SEL_RISE: rdVec = riseReg;
      default:  rdVec = '0;
    endcase
    rdData = cmd.hiHalf ? rdVec[NUM_PINS-1 -: HALF_W] : rdVec[HALF_W-1:0];
  end

  assign irqOut = |(pendVec & enReg);

  // R9: the request needs a pending pin behind it
  p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (|pendVec));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gid_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  input  logic [31:0]       pinIn,
  output logic              irqOut
);

  localparam int NUM_PINS = 2 * HALF_W;

  busCmd_t cmd;

  gid_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .cmd       (cmd)
  );

  gid_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .pinIn  (pinIn),
    .rdData (busRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/100ps
module gpio_irq_detect_bench;

  localparam logic [5:0] A_STAT = 6'h08, A_EN = 6'h0C, A_TYPE = 6'h10,
                         A_LVL = 6'h14, A_HOLD = 6'h18, A_FALL = 6'h20,
                         A_RISE = 6'h24;

  logic        clk = 0, rst_n = 0, busWrEn = 0;
  logic [5:0]  busAddr = 0;
  logic [15:0] busWrData = 0, busRdData;
  logic [31:0] pinIn = 0;
  logic        irqOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_detect u_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn), .irqOut(irqOut));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(posedge clk);
    #0.5 busWrEn = 0;
  endtask

  task automatic wr32(input logic [5:0] a, input logic [31:0] d);
    wr(a, d[15:0]);
    wr(a + 6'd2, d[31:16]);
  endtask

  task automatic rd32(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #0.5 v[15:0] = busRdData;
    busAddr = a + 6'd2;
    #0.5 v[31:16] = busRdData;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [5:0] cfgA [6] = '{A_EN, A_TYPE, A_LVL, A_HOLD, A_FALL, A_RISE};
    logic [31:0] lvlPat [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hF0F0_0F0F};
    logic [31:0] pinPat [4] = '{32'hA5A5_5A5A, 32'h0000_0000, 32'h1234_5678, 32'h00FF_FF00};
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;

    // R1 reset state
    foreach (cfgA[i]) begin rd32(cfgA[i], v); chk("R1 cfg reset", v, 0); end
    settle();
    rd32(A_STAT, v); chk("R1 status low-active default", v, 32'hFFFF_FFFF);
    chk("R1 irq low", irqOut, 0);

    // R2 readback and unmapped addresses
    foreach (cfgA[i]) begin
      wr32(cfgA[i], 32'h9C3E_71A5 ^ (32'h0101_0101 * i));
      rd32(cfgA[i], v); chk("R2 readback", v, 32'h9C3E_71A5 ^ (32'h0101_0101 * i));
    end
    wr(6'h02, 16'hFFFF); rd32(6'h00, v); chk("R2 unmapped read", v, 0);
    wr(6'h0D, 16'h0000); rd32(A_EN, v); chk("R2 odd write ignored", v, 32'h9C3E_71A5);
    rd32(6'h0D, v); chk("R2 odd read", v[15:0], 0);
    foreach (cfgA[i]) wr32(cfgA[i], 0);

    // R4 / R10 level sweep with hold forced on
    wr32(A_HOLD, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      wr32(A_LVL, lvlPat[k]);
      @(negedge clk) pinIn = pinPat[k];
      settle();
      rd32(A_STAT, v); chk("R4 R10 level status", v, ~(pinPat[k] ^ lvlPat[k]));
      wr32(A_STAT, 32'hFFFF_FFFF);
      rd32(A_STAT, v); chk("R4 clear has no lasting effect", v, ~(pinPat[k] ^ lvlPat[k]));
    end

    // R5 / R6 edge qualifiers with hold
    @(negedge clk) pinIn = 0;
    wr32(A_RISE, 32'hAAAA_AAAA);
    wr32(A_FALL, 32'hCCCC_CCCC);
    wr32(A_TYPE, 32'hFFFF_FFFF);
    settle();
    wr32(A_STAT, 32'hFFFF_FFFF);
    rd32(A_STAT, v); chk("R6 cleared", v, 0);
    @(negedge clk) pinIn = 32'hFFFF_FFFF;
    settle();
    rd32(A_STAT, v); chk("R5 rising qualifier", v, 32'hAAAA_AAAA);
    wr32(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk) pinIn = 0;
    settle();
    rd32(A_STAT, v); chk("R5 falling qualifier", v, 32'hCCCC_CCCC);
    repeat (10) @(posedge clk);
    rd32(A_STAT, v); chk("R6 sticky", v, 32'hCCCC_CCCC);
    wr32(A_STAT, 0);
    rd32(A_STAT, v); chk("R6 write zero", v, 32'hCCCC_CCCC);
    wr(A_STAT, 16'h0004);
    rd32(A_STAT, v); chk("R6 clear low bit", v, 32'hCCCC_CCC8);
    wr(A_STAT + 6'd2, 16'h8000);
    rd32(A_STAT, v); chk("R6 clear high bit", v, 32'h4CCC_CCC8);

    // R9 enable sweep over every pin
    for (int i = 0; i < 32; i++) begin
      wr32(A_EN, 32'h1 << i);
      @(negedge clk);
      chk("R9 irq per pin", irqOut, (32'h4CCC_CCC8 >> i) & 1);
    end
    wr32(A_EN, 0);
    @(negedge clk); chk("R9 irq all disabled", irqOut, 0);

    // R3 synchroniser latency on pin 1 (rising qualified)
    wr32(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk) pinIn[1] = 1;
    repeat (2) @(posedge clk);
    rd32(A_STAT, v); chk("R3 not before two edges", v, 0);
    @(posedge clk);
    rd32(A_STAT, v); chk("R3 visible after third edge", v, 32'h2);

    // R7 event and clear in the same cycle
    @(negedge clk) pinIn[1] = 0;
    settle();
    rd32(A_STAT, v); chk("R7 pre-state held", v, 32'h2);
    @(negedge clk) pinIn[1] = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    busAddr = A_STAT; busWrData = 16'h0002; busWrEn = 1;
    @(posedge clk);
    #0.5 busWrEn = 0;
    rd32(A_STAT, v); chk("R7 event wins", v, 32'h2);
    wr(A_STAT, 16'h0002);
    rd32(A_STAT, v); chk("R7 later clear works", v, 0);

    // R8 pass-through edge pulse
    wr32(A_HOLD, 0);
    wr32(A_RISE, 32'hFFFF_FFFF);
    @(negedge clk) pinIn = 0;
    settle();
    @(negedge clk) pinIn = 32'h0F0F_F00F;
    repeat (3) @(posedge clk);
    rd32(A_STAT, v); chk("R8 pulse present", v, 32'h0F0F_F00F);
    @(posedge clk);
    rd32(A_STAT, v); chk("R8 pulse gone", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule